// File: doc/BRIEF.md
# Two-Lane Key Identifier Echo Receiver

This block is the receiving side of a slow two-lane synchronous link. The sender marks the start of a transfer with a strobe and supplies its own bit clock. On every rising edge of that clock it presents one bit on each of two data lanes. The receiver runs on a much faster system clock and samples all four incoming lines through synchronizers. It looks for edges on the strobe and the bit clock. On each bit-clock rise it captures the two lane bits and returns them at once on two echo lines, well inside half a bit period, so that the sender can compare them.

After fourteen bit pairs the receiver has the full 28-bit key identifier. It publishes the identifier with a one-cycle valid pulse and keeps the last echo pair on the return lines for a programmable hold time. It then releases the lines low. If the bit clock stops mid-transfer for longer than a programmable number of bit periods, the transfer is abandoned and the receiver waits for a new strobe.

Top module: `key_id_rx`

## Requirements
- R1: After reset both echo lines are low, the valid pulse is low and the identifier output is all zeros.
- R2: A transfer starts only on a rising edge of the synchronized strobe. Bit-clock rises seen while idle leave both echo lines low and raise no valid pulse.
- R3: During a transfer, each bit-clock rise captures both lanes. Three system-clock cycles after the raw edge, the echo lines show that pair (echo0 from lane 0, echo1 from lane 1). They hold the pair until the next rise.
- R4: The n-th captured lane-0 bit (n = 0..13) lands in identifier bit 27-n, and the n-th lane-1 bit lands in bit 13-n, so each lane is most significant bit first.
- R5: The 14th rise produces a valid pulse of exactly one cycle in the same cycle as its echo. The identifier output changes in that cycle and holds its value until the next completed transfer.
- R6: After the 14th rise, the final echo pair stays on the lines for HOLD_CYC system-clock cycles and then both lines go low.
- R7: If no bit-clock rise arrives for IDLE_PERIODS*BIT_CYC system-clock cycles during a transfer, the transfer is abandoned. Both echo lines go low, no valid pulse is given and the identifier output is left unchanged.
- R8: After an abandoned transfer, a new strobe rise starts a fresh transfer from identifier bit position 0 of each lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Asynchronous transfer-start strobe |
| bclk_i | input | 1 | Asynchronous bit clock from the sender |
| lane0_i | input | 1 | Data lane carrying identifier bits 27..14 |
| lane1_i | input | 1 | Data lane carrying identifier bits 13..0 |
| echo0_o | output | 1 | Return line for the lane-0 bit last captured |
| echo1_o | output | 1 | Return line for the lane-1 bit last captured |
| key_id_o | output | 28 | Last completed key identifier |
| key_valid_o | output | 1 | One-cycle pulse when a new identifier is ready |

## Verification
The bench builds the receiver with BIT_CYC=8, IDLE_PERIODS=2 and HOLD_CYC=10. With these values a whole 14-bit transfer fits in about 120 system clocks. They also put the abort window of 16 cycles and the 10-cycle echo hold within a few dozen cycles of the last edge, so the bench can count both down exactly. The short limits also let it abort one transfer part-way and then finish a fresh one inside a short run.

// File: rtl/key_id_pkg.sv
package key_id_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_HOLD = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic l0;
        logic l1;
    } lane_pair_t;

    localparam int NUM_LANES = 2;

    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/kid_sync.sv
module kid_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d[b]};
            end
            assign q[b] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/kid_lane_shift.sv
module kid_lane_shift #(
    parameter int BITS = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            shift_en,
    input  logic            bit_in,
    output logic [BITS-1:0] word_next
);
    logic [BITS-1:0] q;

    assign word_next = {q[BITS-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (shift_en) q <= word_next;
    end
endmodule

// File: rtl/kid_ctrl.sv
module kid_ctrl
    import key_id_pkg::*;
#(
    parameter int LANE_BITS  = 14,
    parameter int IDLE_LIMIT = 16,
    parameter int HOLD_CYC   = 10,
    localparam int ID_W      = 2 * LANE_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sync_rise,
    input  logic            clk_rise,
    input  lane_pair_t      pair,
    input  logic [ID_W-1:0] word_next,
    output logic            shift_en,
    output lane_pair_t      echo,
    output logic [ID_W-1:0] key_id,
    output logic            key_valid
);
    localparam int CNT_W  = cnt_w(LANE_BITS);
    localparam int TMR_W  = cnt_w(IDLE_LIMIT);
    localparam int HOLD_W = cnt_w(HOLD_CYC);

    rx_state_e         state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [TMR_W-1:0]  idle_tmr;
    logic [HOLD_W-1:0] hold_cnt;

    assign shift_en = clk_rise && (state == ST_RECV);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            idle_tmr  <= '0;
            hold_cnt  <= '0;
            echo      <= '0;
            key_id    <= '0;
            key_valid <= 1'b0;
        end else begin
            key_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (sync_rise) begin
                        state    <= ST_RECV;
                        bit_cnt  <= '0;
                        idle_tmr <= '0;
                        echo     <= '0;
                    end
                end
                ST_RECV: begin
                    if (clk_rise) begin
                        echo     <= pair;
                        idle_tmr <= '0;
                        if (bit_cnt == CNT_W'(LANE_BITS - 1)) begin
                            key_id    <= word_next;
                            key_valid <= 1'b1;
                            state     <= ST_HOLD;
                            hold_cnt  <= '0;
                            bit_cnt   <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end else if (idle_tmr == TMR_W'(IDLE_LIMIT - 1)) begin
                        state    <= ST_IDLE;
                        echo     <= '0;
                        bit_cnt  <= '0;
                        idle_tmr <= '0;
                    end else begin
                        idle_tmr <= idle_tmr + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (hold_cnt == HOLD_W'(HOLD_CYC - 1)) begin
                        state    <= ST_IDLE;
                        echo     <= '0;
                        hold_cnt <= '0;
                    end else begin
                        hold_cnt <= hold_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2/R6/R7: the return lines are low whenever no transfer or hold is active
    a_r2_idle_echo_low: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (echo == '0));

    // R3: inside a transfer the echo moves only after a detected clock rise
    a_r3_echo_only_on_rise: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECV && $past(state) == ST_RECV && !$past(clk_rise)) |-> $stable(echo));

    // R5: valid is a single-cycle pulse
    a_r5_valid_single: assert property (@(posedge clk) disable iff (rst)
        key_valid |=> !key_valid);

    // R5: valid only marks the step from receiving into holding
    a_r5_valid_from_recv: assert property (@(posedge clk) disable iff (rst)
        key_valid |-> ($past(state) == ST_RECV && state == ST_HOLD));

    // R6: the final pair does not move during the hold
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && $past(state) == ST_HOLD) |-> $stable(echo));

    // R7: the silence timer never passes its abort limit
    a_r7_timer_bound: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECV) |-> (idle_tmr < TMR_W'(IDLE_LIMIT)));

    // R4: the bit counter stays within one lane
    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        bit_cnt < CNT_W'(LANE_BITS));
endmodule

// File: rtl/key_id_rx.sv
module key_id_rx
    import key_id_pkg::*;
#(
    parameter int LANE_BITS    = 14,
    parameter int SYNC_STAGES  = 2,
    parameter int BIT_CYC      = 20_000_000,
    parameter int IDLE_PERIODS = 3,
    parameter int HOLD_CYC     = 24_000_000,
    localparam int ID_W        = 2 * LANE_BITS,
    localparam int IDLE_LIMIT  = IDLE_PERIODS * BIT_CYC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sync_i,
    input  logic            bclk_i,
    input  logic            lane0_i,
    input  logic            lane1_i,
    output logic            echo0_o,
    output logic            echo1_o,
    output logic [ID_W-1:0] key_id_o,
    output logic            key_valid_o
);
    logic [3:0] raw_in, synced;
    logic       sync_s, bclk_s, sync_q, bclk_q;
    logic       sync_rise, clk_rise, shift_en;
    logic [NUM_LANES-1:0] lane_s;
    logic [LANE_BITS-1:0] lane_next [NUM_LANES];
    lane_pair_t pair, echo;

    assign raw_in = {sync_i, bclk_i, lane0_i, lane1_i};

    kid_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw_in), .q(synced)
    );

    assign sync_s    = synced[3];
    assign bclk_s    = synced[2];
    assign lane_s[0] = synced[1];
    assign lane_s[1] = synced[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            bclk_q <= 1'b0;
        end else begin
            sync_q <= sync_s;
            bclk_q <= bclk_s;
        end
    end

    assign sync_rise = sync_s & ~sync_q;
    assign clk_rise  = bclk_s & ~bclk_q;
    assign pair      = '{l0: lane_s[0], l1: lane_s[1]};

    genvar g;
    generate
        for (g = 0; g < NUM_LANES; g++) begin : g_lane
            kid_lane_shift #(.BITS(LANE_BITS)) u_lane (
                .clk(clk), .rst(rst), .shift_en(shift_en),
                .bit_in(lane_s[g]), .word_next(lane_next[g])
            );
        end
    endgenerate

    kid_ctrl #(
        .LANE_BITS(LANE_BITS), .IDLE_LIMIT(IDLE_LIMIT), .HOLD_CYC(HOLD_CYC)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .sync_rise(sync_rise), .clk_rise(clk_rise), .pair(pair),
        .word_next({lane_next[0], lane_next[1]}),
        .shift_en(shift_en), .echo(echo),
        .key_id(key_id_o), .key_valid(key_valid_o)
    );

    assign echo0_o = echo.l0;
    assign echo1_o = echo.l1;
endmodule

// File: tb/sim_key_id_rx.sv
`timescale 1ns/1ps
module sim_key_id_rx;
    localparam int BIT_CYC = 8;
    localparam int IDLE_P  = 2;
    localparam int HOLD    = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_i = 1'b0, bclk_i = 1'b0, lane0_i = 1'b0, lane1_i = 1'b0;
    logic echo0_o, echo1_o, key_valid_o;
    logic [27:0] key_id_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [27:0] exp_q[$];
    logic [27:0] last_id = '0;

    always #2.5 clk = ~clk;

    key_id_rx #(
        .BIT_CYC(BIT_CYC), .IDLE_PERIODS(IDLE_P), .HOLD_CYC(HOLD)
    ) u0 (
        .clk(clk), .rst(rst), .sync_i(sync_i), .bclk_i(bclk_i),
        .lane0_i(lane0_i), .lane1_i(lane1_i), .echo0_o(echo0_o),
        .echo1_o(echo1_o), .key_id_o(key_id_o), .key_valid_o(key_valid_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Monitor: scoreboard pop on each valid pulse (R4, R5)
    always @(negedge clk) begin
        if (!rst && key_valid_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5/R7", "unexpected valid", {4'h0, key_id_o}, 32'h0);
            end else begin
                logic [27:0] e;
                e = exp_q.pop_front();
                check(key_id_o == e, "R4", "assembled id", {4'h0, key_id_o}, {4'h0, e});
            end
        end
    end

    // Driver: strobe, then nbits bit pairs with echo checks (R3, R6)
    task automatic send_id(input logic [27:0] id, input int nbits);
        if (nbits == 14) exp_q.push_back(id);
        sync_i = 1'b1;
        wait_n(BIT_CYC);
        sync_i = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            bclk_i  = 1'b0;
            lane0_i = id[27-i];
            lane1_i = id[13-i];
            wait_n(BIT_CYC/2);
            bclk_i = 1'b1;
            wait_n(3);
            check({echo0_o, echo1_o} == {id[27-i], id[13-i]}, "R3", "echo pair",
                  {30'h0, echo0_o, echo1_o}, {30'h0, id[27-i], id[13-i]});
            wait_n(1);
        end
        if (nbits == 14) begin
            // now one cycle past the final capture edge
            wait_n(HOLD - 2);
            check({echo0_o, echo1_o} == {id[14], id[0]}, "R6", "echo held at end",
                  {30'h0, echo0_o, echo1_o}, {30'h0, id[14], id[0]});
            wait_n(1);
            check({echo0_o, echo1_o} == 2'b00, "R6", "echo released",
                  {30'h0, echo0_o, echo1_o}, 32'h0);
            last_id = id;
        end
        bclk_i = 1'b0;
        lane0_i = 1'b0;
        lane1_i = 1'b0;
        wait_n(BIT_CYC);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        rst = 1'b0;
        wait_n(1);
        // R1: reset state
        check({echo0_o, echo1_o, key_valid_o} == 3'b000, "R1", "outputs after reset",
              {29'h0, echo0_o, echo1_o, key_valid_o}, 32'h0);
        check(key_id_o == '0, "R1", "id after reset", {4'h0, key_id_o}, 32'h0);

        // R2: bit clock without a strobe is ignored
        for (int i = 0; i < 3; i++) begin
            bclk_i = 1'b0; lane0_i = 1'b1; lane1_i = 1'b1;
            wait_n(BIT_CYC/2);
            bclk_i = 1'b1;
            wait_n(3);
            check({echo0_o, echo1_o} == 2'b00, "R2", "echo while idle",
                  {30'h0, echo0_o, echo1_o}, 32'h0);
            wait_n(1);
        end
        bclk_i = 1'b0; lane0_i = 1'b0; lane1_i = 1'b0;
        wait_n(BIT_CYC);

        send_id(28'hABCDEF1, 14);
        send_id(28'h0000001, 14);
        send_id(28'h8000000, 14);
        send_id(28'hFFFFFFF, 14);

        // R7: abandon a transfer after five pairs
        send_id(28'h5A5A5A5, 5);
        wait_n(IDLE_P * BIT_CYC + 10);
        check({echo0_o, echo1_o} == 2'b00, "R7", "echo after abort",
              {30'h0, echo0_o, echo1_o}, 32'h0);
        check(key_id_o == last_id, "R7", "id unchanged after abort",
              {4'h0, key_id_o}, {4'h0, last_id});

        // R8: fresh transfer after an abort starts from bit 0
        send_id(28'h2468ACE, 14);
        send_id(28'h13579BD, 14);

        // R5: id held between transfers
        wait_n(20);
        check(key_id_o == 28'h13579BD, "R5", "id held", {4'h0, key_id_o}, 32'h013579BD);
        check(exp_q.size() == 0, "R5", "all expected ids seen",
              exp_q.size(), 32'h0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule